// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of entering an exception or interrupt in a small 32-bit RISC core. Each cycle it looks at a synchronous exception request with its cause code and at two level-sensitive interrupt lines (external device and tick timer), and decides whether to take an exception. When it does, in one step it saves the return PC, the faulting address when that applies, and the old status word. It also rewrites the status and power-management registers, invalidates any load-link reservation, and produces the vector address that redirects instruction fetch.

The status and power-management registers live inside the block. The core updates them through simple write ports. The delay-slot flag, current PC and relocation controls are plain inputs from the pipeline. Every output is registered, so a redirect appears in the cycle after the request is sampled.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Under synchronous reset the status word is 0x0001 (only supervisor bit 0 set). Power-management, saved PC, fault address and saved status are zero, and all pulse outputs are low.
- R2: A synchronous request with a cause from 1 to 14 gives a one-cycle redirect_valid pulse in the next cycle. The redirect PC is cause shifted left by 8, and the saved PC is the current PC.
- R3: For cause 12 (system call) the saved PC is the current PC plus 4.
- R4: When the delay-slot input is high at entry, the saved PC is reduced by 4, status bit 5 is set and the delay-slot clear pulse fires. Entry outside a delay slot clears bit 5.
- R5: Cause 7 (illegal instruction) loads the fault address register with the current PC. Any other entry leaves that register unchanged.
- R6: Entry copies the old status word into saved status. It sets status bit 0 and clears bits 1 (external enable), 2 (tick enable), 3 (data MMU), 4 (instruction MMU) and 5, keeping the others. It clears power-management bits 0 (doze) and 1 (sleep), keeping the others.
- R7: When relocation is enabled, the vector is ORed with the base input. When status bit 6 is set, it is ORed with 0xF000_0000.
- R8: An external interrupt (vector cause 8) is taken only with status bit 1 set. A tick interrupt (cause 5) is taken only with bit 2 set. When both are pending and enabled, tick is taken.
- R9: A synchronous request wins over pending interrupts in the same cycle.
- R10: A request with cause 0 or 15 pulses the unhandled output in the next cycle. It changes no state and does not redirect.
- R11: Every entry pulses the reservation-kill output together with the redirect.
- R12: A status or power-management write loads the register in the next cycle. If entry happens in the same cycle, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | PC of the instruction at the commit point |
| dslot_i | input | 1 | Instruction at the commit point sits in a delay slot |
| reloc_en_i | input | 1 | Enable vector base relocation |
| vec_base_i | input | 32 | Vector base ORed into vectors when relocation is enabled |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 4 | Cause code of the synchronous request |
| ext_irq_i | input | 1 | External interrupt level |
| tick_irq_i | input | 1 | Tick timer interrupt level |
| sr_wr_en_i | input | 1 | Status write strobe |
| sr_wr_data_i | input | 16 | Status write value |
| pmr_wr_en_i | input | 1 | Power-management write strobe |
| pmr_wr_data_i | input | 8 | Power-management write value |
| redir_valid_o | output | 1 | Fetch redirect pulse |
| redir_pc_o | output | 32 | Vector address |
| epc_o | output | 32 | Saved return PC |
| eear_o | output | 32 | Saved fault address |
| esr_o | output | 16 | Saved status word |
| sr_o | output | 16 | Current status word |
| pmr_o | output | 8 | Current power-management word |
| dslot_clr_o | output | 1 | Clear the core's delay-slot flag |
| resv_kill_o | output | 1 | Invalidate load-link reservation |
| unhandled_o | output | 1 | Request carried an unsupported cause |

## Verification
The hardest situations to reach are the collisions: an entry in the same cycle as a status write, a synchronous request while both interrupt lines are pending, and an interrupt line that stays high after being taken. The bench reaches each one on purpose. It holds the interrupt lines low while the enables are written, then raises several strobes in a single cycle. It then keeps sampling after the entry to show that the cleared enables stop a second take while the line is still high.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int SR_SM    = 0;
  localparam int SR_IEE   = 1;
  localparam int SR_TEE   = 2;
  localparam int SR_DME   = 3;
  localparam int SR_IME   = 4;
  localparam int SR_DSX   = 5;
  localparam int SR_EPH   = 6;
  localparam int PMR_DOZE = 0;
  localparam int PMR_SLP  = 1;
  localparam int CAUSE_W  = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 4'd0,
    CAUSE_RESET   = 4'd1,
    CAUSE_BUSERR  = 4'd2,
    CAUSE_DPAGE   = 4'd3,
    CAUSE_IPAGE   = 4'd4,
    CAUSE_TICK    = 4'd5,
    CAUSE_ALIGN   = 4'd6,
    CAUSE_ILLEGAL = 4'd7,
    CAUSE_EXT     = 4'd8,
    CAUSE_DTLB    = 4'd9,
    CAUSE_ITLB    = 4'd10,
    CAUSE_RANGE   = 4'd11,
    CAUSE_SYSCALL = 4'd12,
    CAUSE_FPU     = 4'd13,
    CAUSE_TRAP    = 4'd14,
    CAUSE_BAD     = 4'd15
  } cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic   exc_req,
  input  cause_e exc_cause,
  input  logic   ext_irq,
  input  logic   tick_irq,
  input  logic   ext_en,
  input  logic   tick_en,
  output logic   take,
  output logic   unhandled,
  output cause_e sel_cause
);
  logic bad_code;
  assign bad_code = (exc_cause == CAUSE_NONE) || (exc_cause == CAUSE_BAD);

  // Priority: synchronous request, then tick, then external device.
  always_comb begin
    take      = 1'b0;
    unhandled = 1'b0;
    sel_cause = CAUSE_NONE;
    if (exc_req) begin
      if (bad_code) begin
        unhandled = 1'b1;
      end else begin
        take      = 1'b1;
        sel_cause = exc_cause;
      end
    end else if (tick_irq && tick_en) begin
      take      = 1'b1;
      sel_cause = CAUSE_TICK;
    end else if (ext_irq && ext_en) begin
      take      = 1'b1;
      sel_cause = CAUSE_EXT;
    end
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int VEC_SHIFT     = 8,
  parameter int HIGH_BITS     = 4,
  parameter bit RELOC_SUPPORT = 1'b1
) (
  input  cause_e              cause,
  input  logic                reloc_en,
  input  logic [ADDR_W-1:0]   base,
  input  logic                high_page,
  output logic [ADDR_W-1:0]   vec
);
  localparam logic [ADDR_W-1:0] HIGH_MASK =
    {{HIGH_BITS{1'b1}}, {(ADDR_W-HIGH_BITS){1'b0}}};

  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] reloc_part;

  assign raw = {{(ADDR_W-CAUSE_W){1'b0}}, cause} << VEC_SHIFT;

  generate
    if (RELOC_SUPPORT) begin : g_reloc
      assign reloc_part = reloc_en ? base : '0;
    end else begin : g_fixed
      assign reloc_part = '0;
    end
  endgenerate

  assign vec = raw | reloc_part | (high_page ? HIGH_MASK : '0);
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 16,
  parameter int PMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  cause_e            sel_cause,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dslot,
  input  logic              sr_wr_en,
  input  logic [SR_W-1:0]   sr_wr_data,
  input  logic              pmr_wr_en,
  input  logic [PMR_W-1:0]  pmr_wr_data,
  output logic [SR_W-1:0]   sr_q,
  output logic [PMR_W-1:0]  pmr_q,
  output logic [ADDR_W-1:0] epc_q,
  output logic [ADDR_W-1:0] eear_q,
  output logic [SR_W-1:0]   esr_q
);
  localparam logic [SR_W-1:0]   SR_RESET  = SR_W'(1 << SR_SM);
  localparam logic [SR_W-1:0]   SR_CLR    = SR_W'((1 << SR_IEE) | (1 << SR_TEE) |
                                                  (1 << SR_DME) | (1 << SR_IME) |
                                                  (1 << SR_DSX));
  localparam logic [SR_W-1:0]   SR_DSXBIT = SR_W'(1 << SR_DSX);
  localparam logic [PMR_W-1:0]  PMR_CLR   = PMR_W'((1 << PMR_DOZE) | (1 << PMR_SLP));
  localparam logic [ADDR_W-1:0] WORD      = ADDR_W'(4);

  logic [ADDR_W-1:0] epc_next;
  logic [SR_W-1:0]   sr_entry;

  always_comb begin
    epc_next = pc;
    if (sel_cause == CAUSE_SYSCALL) epc_next = epc_next + WORD;
    if (dslot)                      epc_next = epc_next - WORD;
    sr_entry = (sr_q & ~SR_CLR) | SR_RESET | (dslot ? SR_DSXBIT : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= SR_RESET;
      pmr_q  <= '0;
      epc_q  <= '0;
      eear_q <= '0;
      esr_q  <= '0;
    end else if (take) begin
      esr_q <= sr_q;
      sr_q  <= sr_entry;
      pmr_q <= pmr_q & ~PMR_CLR;
      epc_q <= epc_next;
      if (sel_cause == CAUSE_ILLEGAL) eear_q <= pc;
    end else begin
      if (sr_wr_en)  sr_q  <= sr_wr_data;
      if (pmr_wr_en) pmr_q <= pmr_wr_data;
    end
  end

  // R4: a delay-slot entry leaves the delay-slot-exception bit set
  p_dsx_set_r4: assert property (@(posedge clk) disable iff (rst)
    (take && dslot) |=> sr_q[SR_DSX]);

  // R5: fault address only moves on an illegal-instruction entry
  p_eear_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (take && sel_cause != CAUSE_ILLEGAL) |=> $stable(eear_q));

  // R6: entry lands in supervisor mode with both interrupt enables off
  p_entry_mode_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> (sr_q[SR_SM] && !sr_q[SR_IEE] && !sr_q[SR_TEE]));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SR_W          = 16,
  parameter int PMR_W         = 8,
  parameter int VEC_SHIFT     = 8,
  parameter bit RELOC_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              dslot_i,
  input  logic              reloc_en_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  input  logic              exc_req_i,
  input  logic [3:0]        exc_cause_i,
  input  logic              ext_irq_i,
  input  logic              tick_irq_i,
  input  logic              sr_wr_en_i,
  input  logic [SR_W-1:0]   sr_wr_data_i,
  input  logic              pmr_wr_en_i,
  input  logic [PMR_W-1:0]  pmr_wr_data_i,
  output logic              redir_valid_o,
  output logic [ADDR_W-1:0] redir_pc_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [ADDR_W-1:0] eear_o,
  output logic [SR_W-1:0]   esr_o,
  output logic [SR_W-1:0]   sr_o,
  output logic [PMR_W-1:0]  pmr_o,
  output logic              dslot_clr_o,
  output logic              resv_kill_o,
  output logic              unhandled_o
);
  logic              take;
  logic              unhandled;
  cause_e            sel_cause;
  logic [ADDR_W-1:0] vec;
  logic [SR_W-1:0]   sr_q;

  cause_e            cause_q;
  logic              took_irq_q;

  exc_arbiter u_arb (
    .exc_req   (exc_req_i),
    .exc_cause (cause_e'(exc_cause_i)),
    .ext_irq   (ext_irq_i),
    .tick_irq  (tick_irq_i),
    .ext_en    (sr_q[SR_IEE]),
    .tick_en   (sr_q[SR_TEE]),
    .take      (take),
    .unhandled (unhandled),
    .sel_cause (sel_cause)
  );

  exc_vector_gen #(
    .ADDR_W        (ADDR_W),
    .VEC_SHIFT     (VEC_SHIFT),
    .RELOC_SUPPORT (RELOC_SUPPORT)
  ) u_vec (
    .cause     (sel_cause),
    .reloc_en  (reloc_en_i),
    .base      (vec_base_i),
    .high_page (sr_q[SR_EPH]),
    .vec       (vec)
  );

  exc_state_regs #(
    .ADDR_W (ADDR_W),
    .SR_W   (SR_W),
    .PMR_W  (PMR_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .sel_cause   (sel_cause),
    .pc          (pc_i),
    .dslot       (dslot_i),
    .sr_wr_en    (sr_wr_en_i),
    .sr_wr_data  (sr_wr_data_i),
    .pmr_wr_en   (pmr_wr_en_i),
    .pmr_wr_data (pmr_wr_data_i),
    .sr_q        (sr_q),
    .pmr_q       (pmr_o),
    .epc_q       (epc_o),
    .eear_q      (eear_o),
    .esr_q       (esr_o)
  );

  assign sr_o = sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      dslot_clr_o   <= 1'b0;
      resv_kill_o   <= 1'b0;
      unhandled_o   <= 1'b0;
      cause_q       <= CAUSE_NONE;
      took_irq_q    <= 1'b0;
    end else begin
      redir_valid_o <= take;
      dslot_clr_o   <= take && dslot_i;
      resv_kill_o   <= take;
      unhandled_o   <= unhandled;
      took_irq_q    <= take && !exc_req_i;
      if (take) begin
        redir_pc_o <= vec;
        cause_q    <= sel_cause;
      end
    end
  end

  // R10: an unsupported cause never redirects fetch
  p_unh_no_redir_r10: assert property (@(posedge clk) disable iff (rst)
    unhandled_o |-> !redir_valid_o);

  // R6: saved status equals the status seen one cycle before the redirect
  p_esr_old_r6: assert property (@(posedge clk) disable iff (rst)
    redir_valid_o |-> (esr_o == $past(sr_o)));

  // R8: an external interrupt entry required the enable bit beforehand
  p_ext_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (took_irq_q && cause_q == CAUSE_EXT) |-> $past(sr_o[SR_IEE]));

  // R8: a tick entry required the tick enable beforehand
  p_tick_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (took_irq_q && cause_q == CAUSE_TICK) |-> $past(sr_o[SR_TEE]));

  // R11: reservation kill only accompanies a supervisor-mode redirect
  p_kill_r11: assert property (@(posedge clk) disable iff (rst)
    resv_kill_o |-> (redir_valid_o && sr_o[SR_SM]));

  // R4: delay-slot clear only with a redirect
  p_dsclr_r4: assert property (@(posedge clk) disable iff (rst)
    dslot_clr_o |-> redir_valid_o);
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic        dslot_i = 1'b0;
  logic        reloc_en_i = 1'b0;
  logic [31:0] vec_base_i = '0;
  logic        exc_req_i = 1'b0;
  logic [3:0]  exc_cause_i = '0;
  logic        ext_irq_i = 1'b0;
  logic        tick_irq_i = 1'b0;
  logic        sr_wr_en_i = 1'b0;
  logic [15:0] sr_wr_data_i = '0;
  logic        pmr_wr_en_i = 1'b0;
  logic [7:0]  pmr_wr_data_i = '0;
  logic        redir_valid_o;
  logic [31:0] redir_pc_o, epc_o, eear_o;
  logic [15:0] esr_o, sr_o;
  logic [7:0]  pmr_o;
  logic        dslot_clr_o, resv_kill_o, unhandled_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst(rst), .pc_i(pc_i), .dslot_i(dslot_i),
    .reloc_en_i(reloc_en_i), .vec_base_i(vec_base_i),
    .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
    .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i),
    .sr_wr_en_i(sr_wr_en_i), .sr_wr_data_i(sr_wr_data_i),
    .pmr_wr_en_i(pmr_wr_en_i), .pmr_wr_data_i(pmr_wr_data_i),
    .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
    .epc_o(epc_o), .eear_o(eear_o), .esr_o(esr_o), .sr_o(sr_o),
    .pmr_o(pmr_o), .dslot_clr_o(dslot_clr_o),
    .resv_kill_o(resv_kill_o), .unhandled_o(unhandled_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sr_write(input logic [15:0] v);
    sr_wr_en_i = 1'b1; sr_wr_data_i = v;
    @(negedge clk);
    sr_wr_en_i = 1'b0;
  endtask

  task automatic pmr_write(input logic [7:0] v);
    pmr_wr_en_i = 1'b1; pmr_wr_data_i = v;
    @(negedge clk);
    pmr_wr_en_i = 1'b0;
  endtask

  task automatic fire(input logic [3:0] c, input logic [31:0] pc, input logic ds);
    exc_req_i = 1'b1; exc_cause_i = c; pc_i = pc; dslot_i = ds;
    @(negedge clk);
    exc_req_i = 1'b0; dslot_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "sr", {16'h0, sr_o}, 32'h1);
    chk("R1", "pmr", {24'h0, pmr_o}, 32'h0);
    chk("R1", "epc", epc_o, 32'h0);
    chk("R1", "eear", eear_o, 32'h0);
    chk("R1", "esr", {16'h0, esr_o}, 32'h0);
    chk("R1", "pulses", {29'h0, redir_valid_o, resv_kill_o, unhandled_o}, 32'h0);
  endtask

  task automatic t_basic;
    sr_write(16'h0007);
    fire(4'd2, 32'h0000_1000, 1'b0);
    chk("R2", "redir_valid", {31'h0, redir_valid_o}, 32'h1);
    chk("R2", "redir_pc", redir_pc_o, 32'h0000_0200);
    chk("R2", "epc", epc_o, 32'h0000_1000);
    chk("R11", "resv_kill", {31'h0, resv_kill_o}, 32'h1);
    chk("R4", "no dslot_clr", {31'h0, dslot_clr_o}, 32'h0);
    @(negedge clk);
    chk("R2", "pulse ends", {31'h0, redir_valid_o}, 32'h0);
    chk("R11", "kill ends", {31'h0, resv_kill_o}, 32'h0);
  endtask

  task automatic t_syscall;
    fire(4'd12, 32'h0000_2000, 1'b0);
    chk("R3", "epc", epc_o, 32'h0000_2004);
    chk("R3", "redir_pc", redir_pc_o, 32'h0000_0C00);
  endtask

  task automatic t_dslot;
    fire(4'd6, 32'h0000_3008, 1'b1);
    chk("R4", "epc", epc_o, 32'h0000_3004);
    chk("R4", "dsx set", {31'h0, sr_o[5]}, 32'h1);
    chk("R4", "dslot_clr", {31'h0, dslot_clr_o}, 32'h1);
    chk("R4", "redir_pc", redir_pc_o, 32'h0000_0600);
    fire(4'd12, 32'h0000_4000, 1'b1);
    chk("R4", "syscall in slot epc", epc_o, 32'h0000_4000);
    fire(4'd2, 32'h0000_5000, 1'b0);
    chk("R4", "dsx cleared", {31'h0, sr_o[5]}, 32'h0);
  endtask

  task automatic t_illegal;
    fire(4'd7, 32'h0000_6000, 1'b0);
    chk("R5", "eear loaded", eear_o, 32'h0000_6000);
    fire(4'd2, 32'h0000_7000, 1'b0);
    chk("R5", "eear held", eear_o, 32'h0000_6000);
  endtask

  task automatic t_status;
    sr_write(16'hFF5E);
    pmr_write(8'hA7);
    fire(4'd3, 32'h0000_0100, 1'b0);
    chk("R6", "esr", {16'h0, esr_o}, 32'h0000_FF5E);
    chk("R6", "sr", {16'h0, sr_o}, 32'h0000_FF41);
    chk("R6", "pmr", {24'h0, pmr_o}, 32'h0000_00A4);
    chk("R7", "high page", redir_pc_o, 32'hF000_0300);
  endtask

  task automatic t_vector;
    sr_write(16'h0001);
    reloc_en_i = 1'b1; vec_base_i = 32'h0040_0000;
    fire(4'd13, 32'h0000_0200, 1'b0);
    chk("R7", "reloc", redir_pc_o, 32'h0040_0D00);
    sr_write(16'h0041);
    fire(4'd14, 32'h0000_0200, 1'b0);
    chk("R7", "reloc+high", redir_pc_o, 32'hF040_0E00);
    reloc_en_i = 1'b0; vec_base_i = '0;
  endtask

  task automatic t_irq;
    sr_write(16'h0001);
    ext_irq_i = 1'b1; pc_i = 32'h0000_8000;
    @(negedge clk);
    chk("R8", "ext masked", {31'h0, redir_valid_o}, 32'h0);
    ext_irq_i = 1'b0; tick_irq_i = 1'b1;
    @(negedge clk);
    chk("R8", "tick masked", {31'h0, redir_valid_o}, 32'h0);
    tick_irq_i = 1'b0;
    sr_write(16'h0003);
    ext_irq_i = 1'b1;
    @(negedge clk);
    chk("R8", "ext taken", {31'h0, redir_valid_o}, 32'h1);
    chk("R8", "ext vector", redir_pc_o, 32'h0000_0800);
    chk("R8", "ext epc", epc_o, 32'h0000_8000);
    @(negedge clk);
    chk("R8", "no retake", {31'h0, redir_valid_o}, 32'h0);
    chk("R8", "ie cleared", {31'h0, sr_o[1]}, 32'h0);
    ext_irq_i = 1'b0;
    sr_write(16'h0007);
    ext_irq_i = 1'b1; tick_irq_i = 1'b1;
    @(negedge clk);
    chk("R8", "tick wins", redir_pc_o, 32'h0000_0500);
    ext_irq_i = 1'b0; tick_irq_i = 1'b0;
  endtask

  task automatic t_prio;
    sr_write(16'h0007);
    ext_irq_i = 1'b1; tick_irq_i = 1'b1;
    fire(4'd11, 32'h0000_9000, 1'b0);
    chk("R9", "sync wins", redir_pc_o, 32'h0000_0B00);
    chk("R9", "sync epc", epc_o, 32'h0000_9000);
    ext_irq_i = 1'b0; tick_irq_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_unhandled;
    logic [31:0] epc_before;
    sr_write(16'h0007);
    epc_before = epc_o;
    fire(4'd0, 32'h0000_A000, 1'b0);
    chk("R10", "unhandled 0", {31'h0, unhandled_o}, 32'h1);
    chk("R10", "no redirect 0", {31'h0, redir_valid_o}, 32'h0);
    chk("R10", "sr kept", {16'h0, sr_o}, 32'h0000_0007);
    fire(4'd15, 32'h0000_B000, 1'b0);
    chk("R10", "unhandled 15", {31'h0, unhandled_o}, 32'h1);
    chk("R10", "no redirect 15", {31'h0, redir_valid_o}, 32'h0);
    chk("R10", "epc kept", epc_o, epc_before);
    @(negedge clk);
    chk("R10", "unhandled ends", {31'h0, unhandled_o}, 32'h0);
  endtask

  task automatic t_write;
    sr_write(16'h0013);
    chk("R12", "sr write", {16'h0, sr_o}, 32'h0000_0013);
    pmr_write(8'h5A);
    chk("R12", "pmr write", {24'h0, pmr_o}, 32'h0000_005A);
    sr_wr_en_i = 1'b1; sr_wr_data_i = 16'h00FF;
    pmr_wr_en_i = 1'b1; pmr_wr_data_i = 8'hFF;
    fire(4'd2, 32'h0000_C000, 1'b0);
    sr_wr_en_i = 1'b0; pmr_wr_en_i = 1'b0;
    chk("R12", "entry beats sr write", {16'h0, sr_o}, 32'h0000_0001);
    chk("R12", "esr", {16'h0, esr_o}, 32'h0000_0013);
    chk("R12", "entry beats pmr write", {24'h0, pmr_o}, 32'h0000_0058);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_basic();
    t_syscall();
    t_dslot();
    t_illegal();
    t_status();
    t_vector();
    t_irq();
    t_prio();
    t_unhandled();
    t_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule